// File: doc/BRIEF.md
# Prioritized Interrupt Vector Tracker

This block keeps the pending, in-service and trigger-mode state of 256 interrupt vectors for one processor core. Requests come in on an accept port with a vector number and a level or edge flag. The block decides which pending vector, if any, may be presented to the core. It does this by comparing the 16-vector class of the highest pending vector with a processor priority. That priority comes from a programmable task-priority floor and from the highest vector currently in service.

The core takes the presented vector with an acknowledge pulse. It signals completion with an end-of-interrupt strobe. The block then retires the highest in-service vector and reports which vector it retired and whether that vector was level-triggered. A downstream interrupt router can use that report to re-arm a level source.

Vectors 0 to 15 are reserved. The whole accept path can be switched off with an enable input.

Top module: `vec_tracker`

## Requirements
- R1: After reset, no vector is pending, in service or marked level. Task priority and processor priority read 0x00, `offer_valid` is 0 and `eoi_done` is 0.
- R2: While `offer_valid` is 1, `offer_vector` equals the highest-numbered pending vector.
- R3: `ppr` is combinational. Let T be the task priority and S the highest in-service vector, with S taken as 0 when nothing is in service. If T[7:4] >= S[7:4], `ppr` equals T. Otherwise `ppr` equals {S[7:4], 4'h0}.
- R4: Let H be the highest pending vector. `offer_valid` is 1 only when `enable` is 1 and {H[7:4], 4'h0} is strictly greater than `ppr`. When that value is less than or equal to `ppr`, nothing is offered.
- R5: When `ack` is high in a cycle with `offer_valid` high, the offered vector moves from pending to in service at the next clock edge. `ack` without `offer_valid` has no effect.
- R6: An accepted request whose vector is not already pending sets its pending bit and raises `acc_new` in the same cycle. A request for a vector that is already pending is coalesced: `acc_new` is 0 and only one instance stays pending.
- R7: Every accepted request rewrites the vector's trigger mode: `acc_level`=1 marks the vector level and `acc_level`=0 marks it edge. The mark is reported when the vector is retired.
- R8: An `eoi` pulse retires the highest in-service vector at the next edge and clears its trigger mode. In the cycle after the pulse, `eoi_done` is 1, `eoi_vector` is the retired vector and `eoi_level` is its trigger mode (1 = level). If nothing is in service, `eoi_done` stays 0 and no state changes.
- R9: While `enable` is 0, accept requests are discarded (`acc_new` and `acc_err` are both 0) and `offer_valid` is held at 0.
- R10: An enabled request with a vector below 16 is dropped. It raises `acc_err` in the same cycle, with `acc_new` at 0.
- R11: When an acknowledge and an accept of the same vector occur in one cycle, the acknowledge is applied first. The accept counts as new (`acc_new`=1), and the vector ends up both in service and pending.
- R12: A `tpr_we` pulse loads `tpr_wdata` as task priority at the next clock edge. `ppr` does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Accept and offer enable |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_new | output | 1 | Request newly set a pending bit |
| acc_err | output | 1 | Request named a reserved vector |
| offer_valid | output | 1 | A pending vector is presented to the core |
| offer_vector | output | 8 | Presented vector |
| ack | input | 1 | Core takes the presented vector |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_done | output | 1 | A vector was retired in the previous cycle |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| ppr | output | 8 | Current processor priority |

## Verification
The hardest situation to create from the ports is two nested in-service vectors of different trigger modes. Only then can the bench see that end-of-interrupt retires the higher vector first and returns each vector's own mode. The stimulus gets there in steps:

- accept a level vector, acknowledge it, and check that it now blocks every vector of its own class and below;
- accept an edge vector of a higher class, so that it can pass the raised priority, and acknowledge it;
- issue two end-of-interrupt pulses and check the retired vector and mode reported after each.

The same-cycle acknowledge and re-accept of one vector is also driven deliberately. After it, the vector is hidden behind its own in-service class until it is retired.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
    localparam int RESERVED_VECS = 16;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/pvt_prio_find.sv
module pvt_prio_find #(
    parameter int WORDS = 8,
    parameter int WBITS = 32,
    parameter int IW    = $clog2(WORDS * WBITS)
) (
    input  logic [WORDS*WBITS-1:0] bits,
    output logic                   any,
    output logic [IW-1:0]          idx
);
    localparam int LW = $clog2(WBITS);
    localparam int SW = $clog2(WORDS);

    logic [WORDS-1:0]    word_hit;
    logic [WORDS*LW-1:0] word_pos;

    // Per-word search for the most significant set bit.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [LW-1:0] pos;
        logic          hit;
        always_comb begin
            pos = '0;
            hit = 1'b0;
            for (int j = 0; j < WBITS; j++) begin
                if (bits[w*WBITS + j]) begin
                    pos = LW'(j);
                    hit = 1'b1;
                end
            end
        end
        assign word_hit[w]           = hit;
        assign word_pos[w*LW +: LW]  = pos;
    end

    logic [SW-1:0] sel;
    always_comb begin
        sel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_hit[w]) sel = SW'(w);
        end
    end

    assign any = |word_hit;
    assign idx = {sel, word_pos[sel*LW +: LW]};
endmodule

// File: rtl/pvt_ppr.sv
module pvt_ppr #(
    parameter int VW    = 8,
    parameter int CLS_W = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr
);
    logic [VW-1:0] isr_eff;

    always_comb begin
        isr_eff = isr_any ? isr_top : '0;
        if (tpr[VW-1:CLS_W] >= isr_eff[VW-1:CLS_W])
            ppr = tpr;
        else
            ppr = {isr_eff[VW-1:CLS_W], {CLS_W{1'b0}}};
    end
endmodule

// File: rtl/vec_tracker.sv
module vec_tracker #(
    parameter int NUM_VEC    = 256,
    parameter int WORD_BITS  = 32,
    parameter int CLASS_SIZE = 16,
    parameter int VW         = $clog2(NUM_VEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_vector,
    input  logic          acc_level,
    output logic          acc_new,
    output logic          acc_err,
    output logic          offer_valid,
    output logic [VW-1:0] offer_vector,
    input  logic          ack,
    input  logic          eoi,
    output logic          eoi_done,
    output logic [VW-1:0] eoi_vector,
    output logic          eoi_level,
    input  logic          tpr_we,
    input  logic [VW-1:0] tpr_wdata,
    output logic [VW-1:0] ppr
);
    import pvt_pkg::*;

    localparam int WORDS = NUM_VEC / WORD_BITS;
    localparam int CLS_W = $clog2(CLASS_SIZE);

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VW-1:0]      tpr;
        logic               eoi_done;
        logic [VW-1:0]      eoi_vec;
        trig_e              eoi_trig;
    } state_t;

    state_t st_q, st_d;

    logic          irr_any, isr_any;
    logic [VW-1:0] irr_top, isr_top;
    logic          ack_go, acc_ok, acc_rsv;

    pvt_prio_find #(.WORDS(WORDS), .WBITS(WORD_BITS), .IW(VW)) u_irr_find (
        .bits (st_q.irr),
        .any  (irr_any),
        .idx  (irr_top)
    );

    pvt_prio_find #(.WORDS(WORDS), .WBITS(WORD_BITS), .IW(VW)) u_isr_find (
        .bits (st_q.isr),
        .any  (isr_any),
        .idx  (isr_top)
    );

    pvt_ppr #(.VW(VW), .CLS_W(CLS_W)) u_ppr (
        .tpr     (st_q.tpr),
        .isr_any (isr_any),
        .isr_top (isr_top),
        .ppr     (ppr)
    );

    assign offer_vector = irr_top;
    assign offer_valid  = enable && irr_any &&
                          ({irr_top[VW-1:CLS_W], {CLS_W{1'b0}}} > ppr);

    assign acc_rsv = acc_vector < VW'(RESERVED_VECS);
    assign acc_ok  = acc_valid && enable && !acc_rsv;
    assign acc_err = acc_valid && enable && acc_rsv;
    assign ack_go  = ack && offer_valid;

    always_comb begin
        st_d          = st_q;
        st_d.eoi_done = 1'b0;
        acc_new       = 1'b0;

        // Acknowledge is applied before a same-cycle accept.
        if (ack_go) begin
            st_d.isr[offer_vector] = 1'b1;
            st_d.irr[offer_vector] = 1'b0;
        end

        if (eoi && isr_any) begin
            st_d.isr[isr_top] = 1'b0;
            st_d.eoi_done     = 1'b1;
            st_d.eoi_vec      = isr_top;
            st_d.eoi_trig     = st_q.tmr[isr_top] ? TRIG_LEVEL : TRIG_EDGE;
            st_d.tmr[isr_top] = 1'b0;
        end

        if (tpr_we) st_d.tpr = tpr_wdata;

        if (acc_ok) begin
            acc_new                = !st_d.irr[acc_vector];
            st_d.irr[acc_vector]   = 1'b1;
            st_d.tmr[acc_vector]   = acc_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.eoi_trig <= TRIG_EDGE;
        end else begin
            st_q <= st_d;
        end
    end

    assign eoi_done   = st_q.eoi_done;
    assign eoi_vector = st_q.eoi_vec;
    assign eoi_level  = (st_q.eoi_trig == TRIG_LEVEL);

    // R2: an offered vector is really pending
    p_offer_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> st_q.irr[offer_vector]);

    // R3: processor priority never sits below the task priority
    p_ppr_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= st_q.tpr);

    // R5: acknowledged vector is in service afterwards
    p_ack_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |=> st_q.isr[$past(offer_vector)]);

    // R8: retiring with nothing in service reports nothing
    p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !isr_any) |=> !eoi_done);

    // R9: disabled block neither takes requests nor offers
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!acc_new && !acc_err && !offer_valid));

    // R10: reserved vectors never become pending
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && enable && acc_rsv) |-> (acc_err && !acc_new));

    // R6: an already pending vector that is not being acknowledged coalesces
    p_coalesce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && st_q.irr[acc_vector] && !(ack_go && offer_vector == acc_vector))
        |-> !acc_new);
endmodule

// File: tb/tb_vec_tracker.sv
module tb_vec_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       acc_valid = 1'b0;
    logic [7:0] acc_vector = '0;
    logic       acc_level = 1'b0;
    logic       acc_new, acc_err, offer_valid;
    logic [7:0] offer_vector;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       eoi_done;
    logic [7:0] eoi_vector;
    logic       eoi_level;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic [7:0] ppr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vec_tracker dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .acc_new(acc_new), .acc_err(acc_err),
        .offer_valid(offer_valid), .offer_vector(offer_vector),
        .ack(ack), .eoi(eoi),
        .eoi_done(eoi_done), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ppr(ppr)
    );

    // {tpr, vector, expected offer}
    localparam logic [23:0] TBL [8] = '{
        {8'h00, 8'h10, 8'h01},
        {8'h1F, 8'h20, 8'h01},
        {8'h20, 8'h20, 8'h00},
        {8'h25, 8'h2F, 8'h00},
        {8'h25, 8'h30, 8'h01},
        {8'hF0, 8'hFF, 8'h00},
        {8'hEF, 8'hFF, 8'h01},
        {8'h00, 8'hFF, 8'h01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_accept(input logic [7:0] v, input logic lvl,
                             output logic got_new, output logic got_err);
        acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
        #1;
        got_new = acc_new; got_err = acc_err;
        tick();
        acc_valid = 1'b0;
    endtask

    task automatic do_tpr(input logic [7:0] v);
        tpr_we = 1'b1; tpr_wdata = v;
        tick();
        tpr_we = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        tick();
        eoi = 1'b0;
    endtask

    task automatic drain();
        do_tpr(8'h00);
        for (int i = 0; i < 64; i++) begin
            if (offer_valid) do_ack();
            else do_eoi();
        end
        tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %h expected %h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic n, e;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        enable = 1'b1;
        #1;
        chk("R1 offer_valid", offer_valid, 0);
        chk("R1 ppr", ppr, 8'h00);
        chk("R1 eoi_done", eoi_done, 0);

        // Table: priority gating by class
        for (int k = 0; k < 8; k++) begin
            logic [7:0] t, v, x;
            {t, v, x} = TBL[k];
            do_tpr(t);
            do_accept(v, 1'b0, n, e);
            chk("R6 table new", n, 1);
            chk("R4 table offer", offer_valid, x[0]);
            if (x[0]) chk("R2 table vector", offer_vector, v);
            do_tpr(8'h00);
            chk("R4 table offer floor0", offer_valid, 1);
            do_ack();
            do_eoi();
            chk("R8 table eoi", {eoi_done, eoi_level, eoi_vector}, {1'b1, 1'b0, v});
        end

        // R2 highest pending wins
        do_accept(8'h40, 1'b0, n, e);
        do_accept(8'h85, 1'b0, n, e);
        do_accept(8'h21, 1'b0, n, e);
        chk("R2 highest", {offer_valid, offer_vector}, {1'b1, 8'h85});
        do_ack();
        chk("R3 ppr from isr", ppr, 8'h80);
        chk("R4 blocked by isr", offer_valid, 0);
        do_tpr(8'h95);
        chk("R3 ppr from tpr", ppr, 8'h95);
        do_tpr(8'h10);
        chk("R3 ppr isr again", ppr, 8'h80);
        do_accept(8'h40, 1'b0, n, e);
        chk("R6 coalesced", n, 0);
        do_eoi();
        chk("R8 retire 85", {eoi_done, eoi_level, eoi_vector}, {1'b1, 1'b0, 8'h85});
        chk("R3 ppr after eoi", ppr, 8'h10);
        chk("R4 offer after eoi", {offer_valid, offer_vector}, {1'b1, 8'h40});

        // R7 nested level/edge retire order
        do_accept(8'h50, 1'b1, n, e);
        chk("R6 level new", n, 1);
        chk("R2 offer 50", offer_vector, 8'h50);
        do_ack();
        chk("R3 ppr 50", ppr, 8'h50);
        do_accept(8'h60, 1'b0, n, e);
        chk("R2 offer 60", {offer_valid, offer_vector}, {1'b1, 8'h60});
        do_ack();
        do_eoi();
        chk("R7 retire 60 edge", {eoi_done, eoi_level, eoi_vector}, {1'b1, 1'b0, 8'h60});
        do_eoi();
        chk("R7 retire 50 level", {eoi_done, eoi_level, eoi_vector}, {1'b1, 1'b1, 8'h50});
        tick();
        chk("R8 done is one cycle", eoi_done, 0);
        drain();

        // R8 empty retire
        do_eoi();
        chk("R8 empty eoi", eoi_done, 0);

        // R9 disabled
        enable = 1'b0;
        do_accept(8'h70, 1'b0, n, e);
        chk("R9 discard", {n, e}, 2'b00);
        enable = 1'b1;
        #1;
        chk("R9 nothing pending", offer_valid, 0);
        do_accept(8'h70, 1'b0, n, e);
        enable = 1'b0;
        #1;
        chk("R9 offer held", offer_valid, 0);
        enable = 1'b1;
        #1;
        chk("R9 offer resumes", {offer_valid, offer_vector}, {1'b1, 8'h70});
        drain();

        // R10 reserved
        do_accept(8'h0F, 1'b0, n, e);
        chk("R10 reserved err", {n, e}, 2'b01);
        chk("R10 not pending", offer_valid, 0);

        // R11 ack and re-accept same cycle
        do_accept(8'h90, 1'b0, n, e);
        chk("R11 offer 90", {offer_valid, offer_vector}, {1'b1, 8'h90});
        ack = 1'b1; acc_valid = 1'b1; acc_vector = 8'h90; acc_level = 1'b0;
        #1;
        chk("R11 accept new", acc_new, 1);
        tick();
        ack = 1'b0; acc_valid = 1'b0;
        chk("R11 hidden", offer_valid, 0);
        chk("R11 ppr", ppr, 8'h90);
        do_eoi();
        chk("R11 retire", {eoi_done, eoi_vector}, {1'b1, 8'h90});
        chk("R11 pending again", {offer_valid, offer_vector}, {1'b1, 8'h90});
        drain();

        // R12 tpr write timing
        tpr_we = 1'b1; tpr_wdata = 8'h33;
        #1;
        chk("R12 before edge", ppr, 8'h00);
        tick();
        tpr_we = 1'b0;
        chk("R12 after edge", ppr, 8'h33);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule